// File: doc/BRIEF.md
# Nanosecond Time Counter with Alarm Interrupt

This peripheral keeps a free-running 64-bit count of nanoseconds and compares it with a programmable 64-bit alarm. When the alarm is armed and the count reaches it, the block raises a level interrupt. Software reaches it through a 32-bit register port. The port decodes a byte offset, writes in a single cycle and returns read data combinationally in the same cycle.

Each 64-bit quantity is split into two 32-bit words. For a write, software writes the upper word first. That write is only held in a staging register. The lower-word write then commits the full value: it loads the counter, or it loads and arms the alarm. For a read of the time, software reads the lower word first. That read captures the upper word of the same instant, and the following upper-word read returns the captured value. A carry between the two reads therefore cannot tear the result.

The counter adds `NS_PER_TICK` nanoseconds on every clock. Status, interrupt and arming each have their own clear rules, listed below.

Top module: `nsrtc_top`

## Requirements
- R1: While reset is held, the count, the alarm, the armed flag, the status flag and `irq_o` are all zero, and reads of offsets 0x00, 0x08, 0x10 and 0x18 return zero.
- R2: In every cycle without a commit write to offset 0x00, the count rises by `NS_PER_TICK` (8 by default), and it carries from bit 31 into bit 32.
- R3: A write to offset 0x04 only stages the upper time word. The running count is not changed by it.
- R4: A write to offset 0x00 loads the count with {staged upper word, written data}. The loaded value is visible in the cycle after the write, and counting resumes from it.
- R5: A read of offset 0x00 returns count bits 31:0 and captures count bits 63:32. A read of offset 0x04 returns the captured word, not the live upper half.
- R6: A write to offset 0x0C only stages the upper alarm word. A write to offset 0x08 loads the alarm with {staged upper word, written data} and arms it. Offsets 0x08 and 0x0C read back the committed alarm halves.
- R7: Offset 0x10 reads 1 in bit 0 while the alarm is armed, and 0 otherwise. Its bits 31:1 are zero.
- R8: When the alarm is armed and the count is greater than or equal to the alarm, the next clock disarms the alarm, sets the status flag (offset 0x18, bit 0) and drives `irq_o` high. This also applies to an alarm value already in the past when it is armed.
- R9: `irq_o` stays high until a write with bit 0 set reaches offset 0x1C, and it drops in the cycle after that write.
- R10: A write with bit 0 set to offset 0x14 clears the status flag and disarms the alarm, and it leaves `irq_o` unchanged.
- R11: If an interrupt clear write and an alarm hit fall in the same cycle, the hit wins and `irq_o` stays high.
- R12: Reads of unmapped offsets and of the write-only offsets 0x14 and 0x1C return zero. Writes to unmapped offsets and to the read-only offsets 0x10 and 0x18 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_ofs | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the request |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
The alarm hit and a software interrupt clear can land on the same clock edge, and their priority decides whether an interrupt is lost. The bench arms an alarm at 1000 ns and then commits the time as 960 ns. With 8 ns per tick, the hit is set up for the fifth cycle after the commit, and the bench issues the 0x1C clear write so that its edge is the edge that sets the interrupt. `irq_o` must read high after that edge, and a second clear must then drop it.

// File: rtl/nsrtc_pkg.sv
package nsrtc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CNT_W  = 2 * WORD_W;
    localparam int unsigned OFS_W  = 6;

    // Register offsets (byte addresses on the register port)
    localparam logic [OFS_W-1:0] OFS_TIME_LO  = 6'h00;
    localparam logic [OFS_W-1:0] OFS_TIME_HI  = 6'h04;
    localparam logic [OFS_W-1:0] OFS_ALARM_LO = 6'h08;
    localparam logic [OFS_W-1:0] OFS_ALARM_HI = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_ARMED    = 6'h10;
    localparam logic [OFS_W-1:0] OFS_DISARM   = 6'h14;
    localparam logic [OFS_W-1:0] OFS_STATUS   = 6'h18;
    localparam logic [OFS_W-1:0] OFS_IRQ_ACK  = 6'h1C;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // One-cycle action strobes produced by the decoder
    typedef struct packed {
        logic time_lo_wr;
        logic time_hi_wr;
        logic alarm_lo_wr;
        logic alarm_hi_wr;
        logic disarm;
        logic irq_ack;
        logic time_lo_rd;
    } strobe_t;

    // Read data source selection
    typedef enum logic [2:0] {
        RSEL_ZERO,
        RSEL_TIME_LO,
        RSEL_TIME_HI,
        RSEL_ALARM_LO,
        RSEL_ALARM_HI,
        RSEL_ARMED,
        RSEL_STATUS
    } rsel_e;

    // Register state of the time base
    typedef struct packed {
        cnt_t  count;
        word_t hi_stage;
        word_t snap_hi;
    } tb_state_t;

    // Register state of the alarm unit
    typedef struct packed {
        cnt_t  alarm;
        word_t hi_stage;
        logic  armed;
        logic  status;
        logic  irq;
    } al_state_t;

endpackage

// File: rtl/nsrtc_decode.sv
module nsrtc_decode
    import nsrtc_pkg::*;
(
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  word_t            wdata_i,
    output strobe_t          strb_o,
    output rsel_e            rsel_o
);

    logic wr_go;
    logic rd_go;

    always_comb begin
        wr_go  = sel_i && wr_i;
        rd_go  = sel_i && !wr_i;
        strb_o = '0;
        rsel_o = RSEL_ZERO;

        if (wr_go) begin
            unique case (ofs_i)
                OFS_TIME_LO:  strb_o.time_lo_wr  = 1'b1;
                OFS_TIME_HI:  strb_o.time_hi_wr  = 1'b1;
                OFS_ALARM_LO: strb_o.alarm_lo_wr = 1'b1;
                OFS_ALARM_HI: strb_o.alarm_hi_wr = 1'b1;
                OFS_DISARM:   strb_o.disarm      = wdata_i[0];
                OFS_IRQ_ACK:  strb_o.irq_ack     = wdata_i[0];
                default:      strb_o             = '0;
            endcase
        end

        if (rd_go) begin
            unique case (ofs_i)
                OFS_TIME_LO: begin
                    rsel_o            = RSEL_TIME_LO;
                    strb_o.time_lo_rd = 1'b1;
                end
                OFS_TIME_HI:  rsel_o = RSEL_TIME_HI;
                OFS_ALARM_LO: rsel_o = RSEL_ALARM_LO;
                OFS_ALARM_HI: rsel_o = RSEL_ALARM_HI;
                OFS_ARMED:    rsel_o = RSEL_ARMED;
                OFS_STATUS:   rsel_o = RSEL_STATUS;
                default:      rsel_o = RSEL_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/nsrtc_timebase.sv
module nsrtc_timebase
    import nsrtc_pkg::*;
#(
    parameter int unsigned NS_PER_TICK = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t strb_i,
    input  word_t   wdata_i,
    output cnt_t    count_o,
    output word_t   snap_hi_o
);

    localparam cnt_t STEP = CNT_W'(NS_PER_TICK);

    tb_state_t st_d;
    tb_state_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.count = st_q.count + STEP;

        // Upper word is only held until the lower word commits it
        if (strb_i.time_hi_wr) begin
            st_d.hi_stage = wdata_i;
        end

        // Lower-word write loads the whole count; it beats the tick
        if (strb_i.time_lo_wr) begin
            st_d.count = {st_q.hi_stage, wdata_i};
        end

        // Lower-word read captures the matching upper half
        if (strb_i.time_lo_rd) begin
            st_d.snap_hi = st_q.count[CNT_W-1:WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.count;
    assign snap_hi_o = st_q.snap_hi;

endmodule

// File: rtl/nsrtc_alarm.sv
module nsrtc_alarm
    import nsrtc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t strb_i,
    input  word_t   wdata_i,
    input  cnt_t    count_i,
    output cnt_t    alarm_o,
    output logic    armed_o,
    output logic    status_o,
    output logic    irq_o
);

    al_state_t st_d;
    al_state_t st_q;
    logic      hit;

    always_comb begin
        hit  = st_q.armed && (count_i >= st_q.alarm);
        st_d = st_q;

        if (strb_i.alarm_hi_wr) begin
            st_d.hi_stage = wdata_i;
        end

        // Interrupt acknowledge first, so that a hit in the same cycle wins
        if (strb_i.irq_ack) begin
            st_d.irq = 1'b0;
        end

        if (hit) begin
            st_d.armed  = 1'b0;
            st_d.status = 1'b1;
            st_d.irq    = 1'b1;
        end

        // Software disarm clears status and arming, not the interrupt line
        if (strb_i.disarm) begin
            st_d.armed  = 1'b0;
            st_d.status = 1'b0;
        end

        // Commit of the lower word loads and arms the alarm
        if (strb_i.alarm_lo_wr) begin
            st_d.alarm = {st_q.hi_stage, wdata_i};
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_o  = st_q.alarm;
    assign armed_o  = st_q.armed;
    assign status_o = st_q.status;
    assign irq_o    = st_q.irq;

endmodule

// File: rtl/nsrtc_top.sv
module nsrtc_top
    import nsrtc_pkg::*;
#(
    parameter int unsigned NS_PER_TICK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [OFS_W-1:0] bus_ofs,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq_o
);

    strobe_t strb;
    rsel_e   rsel;
    cnt_t    count_q;
    word_t   snap_hi_q;
    cnt_t    alarm_q;
    logic    armed_q;
    logic    status_q;
    logic    irq_q;

    nsrtc_decode u_decode (
        .sel_i   (bus_sel),
        .wr_i    (bus_wr),
        .ofs_i   (bus_ofs),
        .wdata_i (bus_wdata),
        .strb_o  (strb),
        .rsel_o  (rsel)
    );

    nsrtc_timebase #(
        .NS_PER_TICK (NS_PER_TICK)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_i    (strb),
        .wdata_i   (bus_wdata),
        .count_o   (count_q),
        .snap_hi_o (snap_hi_q)
    );

    nsrtc_alarm u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb_i   (strb),
        .wdata_i  (bus_wdata),
        .count_i  (count_q),
        .alarm_o  (alarm_q),
        .armed_o  (armed_q),
        .status_o (status_q),
        .irq_o    (irq_q)
    );

    always_comb begin
        unique case (rsel)
            RSEL_TIME_LO:  bus_rdata = count_q[WORD_W-1:0];
            RSEL_TIME_HI:  bus_rdata = snap_hi_q;
            RSEL_ALARM_LO: bus_rdata = alarm_q[WORD_W-1:0];
            RSEL_ALARM_HI: bus_rdata = alarm_q[CNT_W-1:WORD_W];
            RSEL_ARMED:    bus_rdata = {{(WORD_W-1){1'b0}}, armed_q};
            RSEL_STATUS:   bus_rdata = {{(WORD_W-1){1'b0}}, status_q};
            default:       bus_rdata = '0;
        endcase
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/nsrtc_checker.sv
module nsrtc_checker
    import nsrtc_pkg::*;
#(
    parameter int unsigned NS_PER_TICK = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [OFS_W-1:0] bus_ofs,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             irq_o,
    input cnt_t             count_q,
    input cnt_t             alarm_q,
    input logic             armed_q
);

    logic time_commit;
    logic alarm_commit;
    logic ack_wr;
    logic unmapped_rd;

    assign time_commit  = bus_sel && bus_wr && (bus_ofs == OFS_TIME_LO);
    assign alarm_commit = bus_sel && bus_wr && (bus_ofs == OFS_ALARM_LO);
    assign ack_wr       = bus_sel && bus_wr && (bus_ofs == OFS_IRQ_ACK) && bus_wdata[0];
    assign unmapped_rd  = bus_sel && !bus_wr &&
                          (bus_ofs != OFS_TIME_LO)  && (bus_ofs != OFS_TIME_HI) &&
                          (bus_ofs != OFS_ALARM_LO) && (bus_ofs != OFS_ALARM_HI) &&
                          (bus_ofs != OFS_ARMED)    && (bus_ofs != OFS_STATUS);

    a_r2_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !time_commit |=> count_q == $past(count_q) + CNT_W'(NS_PER_TICK));

    a_r4_commit_low: assert property (@(posedge clk) disable iff (!rst_n)
        time_commit |=> count_q[WORD_W-1:0] == $past(bus_wdata));

    a_r8_hit_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (count_q >= alarm_q) && !alarm_commit) |=> (irq_o && !armed_q));

    a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_wr) |=> irq_o);

    a_r6_commit_arms: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_commit |=> armed_q);

    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_rd |-> bus_rdata == '0);

endmodule

bind nsrtc_top nsrtc_checker #(
    .NS_PER_TICK (NS_PER_TICK)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_ofs   (bus_ofs),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .count_q   (count_q),
    .alarm_q   (alarm_q),
    .armed_q   (armed_q)
);

// File: tb/tb_nsrtc_top.sv
`timescale 1ns/1ps
module tb_nsrtc_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_wr;
    logic [5:0]  bus_ofs;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    nsrtc_top #(.NS_PER_TICK(8)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_ofs   (bus_ofs),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_ofs = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_ofs = a; bus_wdata = '0;
        #1 v = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h00, v); chk("R1 time low in reset", v, 0);
        rd(6'h08, v); chk("R1 alarm low in reset", v, 0);
        rd(6'h10, v); chk("R1 armed in reset", v, 0);
        rd(6'h18, v); chk("R1 status in reset", v, 0);
        chk("R1 irq in reset", irq_o, 0);
    endtask

    task automatic t_time_load();
        logic [31:0] v;
        wr(6'h04, 32'h1);
        wr(6'h00, 32'h10);
        rd(6'h00, v); chk("R4 loaded low word", v, 32'h10);
        rd(6'h04, v); chk("R4 loaded high word", v, 32'h1);
        rd(6'h00, v); chk("R2 advance by 8 per cycle", v, 32'h20);
    endtask

    task automatic t_time_stage();
        logic [31:0] v;
        wr(6'h04, 32'h55);
        rd(6'h00, v);
        rd(6'h04, v); chk("R3 high write alone leaves count", v, 32'h1);
    endtask

    task automatic t_snapshot();
        logic [31:0] v;
        wr(6'h04, 32'h0);
        wr(6'h00, 32'hFFFF_FFF8);
        rd(6'h00, v); chk("R5 low before carry", v, 32'hFFFF_FFF8);
        rd(6'h04, v); chk("R5 high from capture not live", v, 32'h0);
        rd(6'h00, v); chk("R2 low after carry", v, 32'h8);
        rd(6'h04, v); chk("R2 carry into high word", v, 32'h1);
    endtask

    task automatic t_alarm_stage();
        logic [31:0] v;
        wr(6'h0C, 32'h7);
        rd(6'h0C, v); chk("R6 high alarm only staged", v, 32'h0);
        rd(6'h10, v); chk("R7 not armed by high write", v, 32'h0);
        wr(6'h08, 32'h1234);
        rd(6'h10, v); chk("R7 armed after low write", v, 32'h1);
        rd(6'h08, v); chk("R6 alarm low readback", v, 32'h1234);
        rd(6'h0C, v); chk("R6 alarm high readback", v, 32'h7);
        wr(6'h14, 32'h1);
        rd(6'h10, v); chk("R10 disarm write", v, 32'h0);
    endtask

    task automatic t_fire();
        logic [31:0] v;
        wr(6'h04, 32'h0);
        wr(6'h00, 32'h0);
        wr(6'h0C, 32'h0);
        wr(6'h08, 32'd1000);
        wr(6'h00, 32'd960);
        repeat (5) @(negedge clk);
        chk("R8 no early interrupt", irq_o, 0);
        @(negedge clk);
        chk("R8 interrupt on reach", irq_o, 1);
        rd(6'h18, v); chk("R8 status set", v, 32'h1);
        rd(6'h10, v); chk("R8 disarmed after hit", v, 32'h0);
        repeat (4) @(negedge clk);
        chk("R9 interrupt level held", irq_o, 1);
        wr(6'h14, 32'h1);
        rd(6'h18, v); chk("R10 status cleared", v, 32'h0);
        chk("R10 irq unaffected by disarm", irq_o, 1);
        wr(6'h1C, 32'h0);
        chk("R9 ack with bit0 clear ignored", irq_o, 1);
        wr(6'h1C, 32'h1);
        chk("R9 ack drops interrupt", irq_o, 0);
    endtask

    task automatic t_collide();
        wr(6'h00, 32'h0);
        wr(6'h08, 32'd1000);
        wr(6'h00, 32'd960);
        repeat (5) @(negedge clk);
        chk("R11 quiet before collision", irq_o, 0);
        wr(6'h1C, 32'h1);
        chk("R11 hit wins over ack", irq_o, 1);
        wr(6'h1C, 32'h1);
        chk("R11 later ack clears", irq_o, 0);
    endtask

    task automatic t_past_alarm();
        wr(6'h08, 32'd4);
        chk("R8 past alarm not yet raised", irq_o, 0);
        @(negedge clk);
        chk("R8 past alarm raises", irq_o, 1);
        wr(6'h1C, 32'h1);
        wr(6'h14, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(6'h20, v); chk("R12 unmapped read zero", v, 0);
        rd(6'h14, v); chk("R12 write-only read zero", v, 0);
        wr(6'h24, 32'hFFFF_FFFF);
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h18, v); chk("R12 status unchanged", v, 0);
        rd(6'h10, v); chk("R12 armed unchanged", v, 0);
        rd(6'h08, v); chk("R12 alarm low unchanged", v, 32'd4);
        rd(6'h0C, v); chk("R12 alarm high unchanged", v, 0);
        chk("R12 irq unchanged", irq_o, 0);
    endtask

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_ofs = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_time_load();
        t_time_stage();
        t_snapshot();
        t_alarm_stage();
        t_fire();
        t_collide();
        t_past_alarm();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule